// File: doc/BRIEF.md
# Single-Wire Debug Link Target

This block is the target end of a bidirectional debug link that runs over one pseudo-open-drain pin with a pull-up. The host frames every bit. It pulls the pin low, and the target counts link clocks from that falling edge. On a write bit the target samples the level the host left on the pin. On a read bit the target either holds the pin low for a fixed window or leaves it released. Bits travel most significant first. After eight bits the target presents a received byte, or it has finished sending a byte that it took earlier through a ready/valid handshake.

The host may not know the target's link clock. It can send a synchronization request by holding the pin low for a long time. The target answers with a low pulse of a known number of link clocks, and the host measures that pulse to learn the rate. Every low pulse the target drives ends with a one-link-clock active-high drive, so the rising edge does not depend on the pull-up alone. The link clock is either the bus clock or the rising edges of a slower alternate clock, chosen by a switch input. Command decoding belongs to the logic that consumes the bytes.

Top module: `bdl_target`

## Requirements
- R1: After reset the pin is released (pin_oe = 0), rx_valid is 0 and tx_ready is 1.
- R2: On a host-to-target bit the pin level is sampled SAMPLE_AT (10) link clocks after the detected falling edge. High means 1 and low means 0. The first bit received goes to rx_data[7] (MSB first). After the eighth bit, rx_valid pulses for exactly one bus cycle with the whole byte on rx_data.
- R3: On a target-to-host bit the current MSB of the loaded byte is sent. A 0 drives the pin low for link clocks 0 to 12 of the bit and drives it high for exactly link clock 13 (the speed-up). A 1 leaves the pin released. The active-high drive lasts one link clock and is never applied while the host holds the pin low.
- R4: tx_ready is 1 only when the link is idle between bytes and no transmit byte is pending. A byte is taken on a cycle where tx_valid and tx_ready are both 1. tx_ready then stays 0 until the eight bits of that byte have been read, and rx_valid does not pulse during those bits.
- R5: A host low time of SYNC_DETECT (128) link clocks is a synchronization request, not a bit. Any partly received byte is discarded, so the next eight host bits form a fresh byte.
- R6: After the host releases a synchronization request, the target waits SYNC_DELAY (16) link clocks, drives the pin low for exactly SYNC_LOW (128) link clocks, drives it high for exactly one link clock, and then releases it.
- R7: With clk_sw = 0 the link clock is every bus cycle. With clk_sw = 1 it is each rising edge of alt_clk, and every link-clock timing above scales with it.
- R8: The target's own drive on the pin is never taken as a host falling edge. Neither a read byte nor a synchronization response produces a spurious bit or rx_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sw | input | 1 | 0: link clock is clk; 1: link clock is alt_clk rising edges |
| alt_clk | input | 1 | Alternate clock source, slower than clk/2 |
| pin_in | input | 1 | Level seen on the debug pin |
| pin_oe | output | 1 | Target drives the pin |
| pin_do | output | 1 | Level driven when pin_oe is 1 |
| rx_data | output | W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: rx_data holds a new byte |
| tx_data | input | W | Byte to send to the host |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Target accepts tx_data this cycle |

## Verification
The bench goes after the boundaries of the bit window. Write ones are released well before the sample point and write zeros are held past it, so a design that samples at the wrong count gets the bits wrong. It counts the synchronization pulse to the exact cycle in both clock modes, and it counts speed-up drive cycles per zero bit read. An off-by-one counter, or a speed-up that is missing or lasts two link clocks, shows up as a wrong count. It sends a synchronization request in the middle of a byte and checks that the next byte arrives whole, which catches a design that keeps stale bits. After every read byte and every synchronization response it checks that no extra byte strobe appeared, which catches a design that mistakes its own drive for a host edge.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BIT,
        PH_SYNC_HI,
        PH_SYNC_DLY,
        PH_SYNC_LO,
        PH_SYNC_SPD
    } phase_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/bdl_tick_sel.sv
module bdl_tick_sel #(
    parameter int SYNC_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sw,
    input  logic alt_clk,
    output logic link_tick
);

    typedef struct packed {
        logic [SYNC_W-1:0] alt_sync;
        logic              alt_prev;
        logic              sel;
    } tick_t;

    tick_t d, q;

    always_comb begin
        d          = q;
        d.alt_sync = {q.alt_sync[SYNC_W-2:0], alt_clk};
        d.alt_prev = q.alt_sync[SYNC_W-1];
        d.sel      = clk_sw;
    end

    assign link_tick = q.sel ? (q.alt_sync[SYNC_W-1] & ~q.alt_prev) : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/bdl_pin_sync.sv
module bdl_pin_sync #(
    parameter int STAGES   = 2,
    parameter int MASK_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic drive_on,
    output logic pin_lvl,
    output logic host_fall
);

    localparam int MW = $clog2(MASK_CYC + 1);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
        logic [MW-1:0]     mask;
    } psync_t;

    psync_t d, q;

    assign pin_lvl = q.sync[STAGES-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], pin_in};
        d.prev = pin_lvl;
        if (drive_on)
            d.mask = MW'(MASK_CYC);
        else if (q.mask != '0)
            d.mask = q.mask - 1'b1;
    end

    // a falling edge counts only while the target's own drive is masked out
    assign host_fall = q.prev & ~pin_lvl & (q.mask == '0) & ~drive_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '1;
            q.prev <= 1'b1;
            q.mask <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/bdl_shifter.sv
module bdl_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift_en,
    input  logic         shift_bit,
    input  logic         clear,
    output logic         msb,
    output logic         at_start,
    output logic         byte_done,
    output logic [W-1:0] next_word
);

    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]     word;
        logic [CNT_W-1:0] cnt;
    } shf_t;

    shf_t d, q;

    assign msb       = q.word[W-1];
    assign at_start  = (q.cnt == '0);
    assign next_word = {q.word[W-2:0], shift_bit};
    assign byte_done = shift_en && (q.cnt == CNT_W'(W - 1));

    always_comb begin
        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (load) begin
            d.word = load_word;
            d.cnt  = '0;
        end else if (shift_en) begin
            d.word = next_word;
            d.cnt  = byte_done ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/bdl_target.sv
module bdl_target
    import bdl_pkg::*;
#(
    parameter int W           = 8,
    parameter int SAMPLE_AT   = 10,
    parameter int DRIVE_END   = 13,
    parameter int SYNC_DETECT = 128,
    parameter int SYNC_DELAY  = 16,
    parameter int SYNC_LOW    = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_sw,
    input  logic         alt_clk,
    input  logic         pin_in,
    output logic         pin_oe,
    output logic         pin_do,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    output logic         tx_ready
);

    localparam int unsigned LIMIT = max4(SYNC_DETECT, SYNC_LOW, SYNC_DELAY, DRIVE_END + 1);
    localparam int          CW    = $clog2(LIMIT + 2);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          tx_mode;
        logic          bit_val;
        logic [W-1:0]  rx_word;
        logic          rx_pulse;
    } ctl_t;

    ctl_t d, q;

    logic         link_tick;
    logic         pin_lvl, host_fall;
    logic         sh_load, sh_shift, sh_bit, sh_clear;
    logic         sh_msb, sh_start, sh_done;
    logic [W-1:0] sh_next;
    logic [CW-1:0] cnt_inc;
    logic         tx_low, tx_spd;

    bdl_tick_sel #(.SYNC_W(2)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sw    (clk_sw),
        .alt_clk   (alt_clk),
        .link_tick (link_tick)
    );

    bdl_pin_sync #(.STAGES(2), .MASK_CYC(3)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .drive_on  (pin_oe),
        .pin_lvl   (pin_lvl),
        .host_fall (host_fall)
    );

    bdl_shifter #(.W(W)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (tx_data),
        .shift_en  (sh_shift),
        .shift_bit (sh_bit),
        .clear     (sh_clear),
        .msb       (sh_msb),
        .at_start  (sh_start),
        .byte_done (sh_done),
        .next_word (sh_next)
    );

    assign cnt_inc  = (&q.cnt) ? q.cnt : q.cnt + 1'b1;
    assign tx_ready = (q.phase == PH_IDLE) && !q.tx_mode && sh_start && !host_fall;
    assign sh_load  = tx_valid && tx_ready;

    always_comb begin
        d          = q;
        d.rx_pulse = 1'b0;
        sh_shift   = 1'b0;
        sh_bit     = 1'b0;
        sh_clear   = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (sh_load) d.tx_mode = 1'b1;
                if (host_fall) begin
                    d.phase   = PH_BIT;
                    d.cnt     = '0;
                    d.bit_val = q.tx_mode ? sh_msb : 1'b1;
                end
            end
            PH_BIT: begin
                if (link_tick) d.cnt = cnt_inc;
                if (!q.tx_mode) begin
                    if (link_tick && q.cnt == CW'(SAMPLE_AT))
                        d.bit_val = pin_lvl;
                    if (link_tick && q.cnt == CW'(SYNC_DETECT - 1) && !pin_lvl) begin
                        d.phase  = PH_SYNC_HI;
                        d.cnt    = '0;
                        sh_clear = 1'b1;
                    end else if (q.cnt > CW'(SAMPLE_AT) && pin_lvl) begin
                        sh_shift = 1'b1;
                        sh_bit   = q.bit_val;
                        d.phase  = PH_IDLE;
                        if (sh_done) begin
                            d.rx_word  = sh_next;
                            d.rx_pulse = 1'b1;
                        end
                    end
                end else begin
                    if (q.cnt > CW'(DRIVE_END) && pin_lvl) begin
                        sh_shift = 1'b1;
                        d.phase  = PH_IDLE;
                        if (sh_done) d.tx_mode = 1'b0;
                    end
                end
            end
            PH_SYNC_HI: begin
                if (pin_lvl) begin
                    d.phase = PH_SYNC_DLY;
                    d.cnt   = '0;
                end
            end
            PH_SYNC_DLY: begin
                if (link_tick) begin
                    if (q.cnt == CW'(SYNC_DELAY - 1)) begin
                        d.phase = PH_SYNC_LO;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = cnt_inc;
                    end
                end
            end
            PH_SYNC_LO: begin
                if (link_tick) begin
                    if (q.cnt == CW'(SYNC_LOW - 1)) begin
                        d.phase = PH_SYNC_SPD;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = cnt_inc;
                    end
                end
            end
            PH_SYNC_SPD: begin
                if (link_tick) d.phase = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_comb begin
        tx_low = (q.phase == PH_BIT) && q.tx_mode && !q.bit_val && (q.cnt < CW'(DRIVE_END));
        tx_spd = (q.phase == PH_BIT) && q.tx_mode && !q.bit_val && (q.cnt == CW'(DRIVE_END));
        pin_oe = tx_low || tx_spd || (q.phase == PH_SYNC_LO) || (q.phase == PH_SYNC_SPD);
        pin_do = tx_spd || (q.phase == PH_SYNC_SPD);
    end

    assign rx_data  = q.rx_word;
    assign rx_valid = q.rx_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase    <= PH_IDLE;
            q.cnt      <= '0;
            q.tx_mode  <= 1'b0;
            q.bit_val  <= 1'b1;
            q.rx_word  <= '0;
            q.rx_pulse <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/bdl_target_chk.sv
module bdl_target_chk #(
    parameter int SYNC_LOW = 128
) (
    input logic clk,
    input logic rst_n,
    input logic pin_oe,
    input logic pin_do,
    input logic rx_valid,
    input logic tx_valid,
    input logic tx_ready,
    input logic link_tick
);

    logic [15:0] low_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_ticks <= '0;
        else if (pin_oe && !pin_do) begin
            if (link_tick && low_ticks != 16'hFFFF) low_ticks <= low_ticks + 1'b1;
        end else
            low_ticks <= '0;
    end

    // R1: reset leaves the pin released and no strobe
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (!pin_oe && !rx_valid));

    // R2: byte strobe is a single cycle
    a_r2_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3: active-high drive ends at the next link clock
    a_r3_spd_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && pin_do && link_tick) |=> !(pin_oe && pin_do));

    // R3: nothing is driven while a new byte may be accepted
    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !pin_oe);

    // R4: acceptance withdraws readiness
    a_r4_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R6: no low drive lasts longer than the sync pulse
    a_r6_low_limit: assert property (@(posedge clk) disable iff (!rst_n)
        low_ticks <= 16'(SYNC_LOW));

endmodule

bind bdl_target bdl_target_chk #(.SYNC_LOW(SYNC_LOW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_oe    (pin_oe),
    .pin_do    (pin_do),
    .rx_valid  (rx_valid),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .link_tick (link_tick)
);

// File: tb/sim_bdl_target.sv
module sim_bdl_target;

    logic       clk = 1'b0;
    logic       alt_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_sw = 1'b0;
    logic       host_low = 1'b0;
    logic       pin_oe, pin_do, rx_valid, tx_ready, tx_valid = 1'b0;
    logic [7:0] rx_data, tx_data = 8'h00;
    logic       pin_w;

    int checks = 0, errors = 0;
    int rxv_cnt = 0, spd_cnt = 0, lo_cnt = 0, clash_cnt = 0;

    always #10 clk = ~clk;
    always #80 alt_clk = ~alt_clk;

    assign pin_w = host_low ? 1'b0 : (pin_oe ? pin_do : 1'b1);

    bdl_target u0 (
        .clk(clk), .rst_n(rst_n), .clk_sw(clk_sw), .alt_clk(alt_clk),
        .pin_in(pin_w), .pin_oe(pin_oe), .pin_do(pin_do),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    always @(negedge clk) begin
        if (rx_valid) rxv_cnt++;
        if (pin_oe && pin_do) spd_cnt++;
        if (pin_oe && !pin_do) lo_cnt++;
        if (host_low && pin_oe && pin_do) clash_cnt++;
    end

    // per-entry: bit 8 = 1 read byte from target, 0 write byte to target
    localparam logic [8:0] VEC [8] = '{
        {1'b0, 8'hA5}, {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'h3C},
        {1'b1, 8'h81}, {1'b0, 8'h5A}, {1'b1, 8'h00}, {1'b1, 8'hFF}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_bit(input logic b, input int per);
        int lo;
        lo = b ? 4 * per : 20 * per;
        @(negedge clk);
        host_low = 1'b1;
        wait_clk(lo);
        host_low = 1'b0;
        wait_clk(32 * per - lo);
    endtask

    task automatic write_byte(input logic [7:0] v, input int per);
        for (int i = 7; i >= 0; i--) write_bit(v[i], per);
    endtask

    task automatic read_bit(input int per, output logic b);
        @(negedge clk);
        host_low = 1'b1;
        wait_clk(2);
        host_low = 1'b0;
        wait_clk(6 * per);
        b = pin_w;
        wait_clk(32 * per - 6 * per - 2);
    endtask

    task automatic read_byte(input int per, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            read_bit(per, b);
            v[i] = b;
        end
    endtask

    task automatic offer(input logic [7:0] v);
        @(negedge clk);
        tx_data  = v;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
        #1 tx_valid = 1'b0;
        @(negedge clk);
        chk("R4 ready low after accept", int'(tx_ready), 0);
    endtask

    task automatic do_sync(input int per, input int hold, input int dmin, input int dmax);
        int d, lo0, sp0, rv0;
        lo0 = lo_cnt; sp0 = spd_cnt; rv0 = rxv_cnt;
        @(negedge clk);
        host_low = 1'b1;
        wait_clk(hold);
        host_low = 1'b0;
        d = 0;
        while (!pin_oe && d < 4000) begin @(negedge clk); d++; end
        checks++;
        if (d < dmin || d > dmax) begin
            errors++;
            $display("FAIL R6 sync delay actual=%0d expected=%0d..%0d", d, dmin, dmax);
        end
        wait_clk(140 * per);
        chk("R6 sync low length", lo_cnt - lo0, 128 * per);
        chk("R6 sync speed-up length", spd_cnt - sp0, per);
        chk("R8 no strobe from sync", rxv_cnt - rv0, 0);
        wait_clk(4 * per);
    endtask

    task automatic run_vec(input logic [8:0] e, input int per, input string tag);
        int rv0, sp0, zeros;
        logic [7:0] got;
        rv0 = rxv_cnt; sp0 = spd_cnt;
        if (!e[8]) begin
            write_byte(e[7:0], per);
            chk({tag, " R2 one strobe"}, rxv_cnt - rv0, 1);
            chk({tag, " R2 rx byte"}, int'(rx_data), int'(e[7:0]));
        end else begin
            offer(e[7:0]);
            read_byte(per, got);
            zeros = 8 - $countones(e[7:0]);
            chk({tag, " R3 tx byte msb first"}, int'(got), int'(e[7:0]));
            chk({tag, " R3 speed-up per zero"}, spd_cnt - sp0, zeros * per);
            chk({tag, " R8 no rx strobe in read"}, rxv_cnt - rv0, 0);
            chk({tag, " R4 ready after byte"}, int'(tx_ready), 1);
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_clk(3);
        chk("R1 pin released", int'(pin_oe), 0);
        chk("R1 no strobe", int'(rx_valid), 0);
        chk("R1 ready", int'(tx_ready), 1);
        rst_n = 1'b1;
        wait_clk(5);

        for (int i = 0; i < 8; i++) run_vec(VEC[i], 1, "vec");

        // R5: sync in the middle of a byte drops the partial bits
        write_bit(1'b1, 1);
        write_bit(1'b0, 1);
        write_bit(1'b1, 1);
        do_sync(1, 200, 16, 22);
        run_vec({1'b0, 8'h96}, 1, "R5 after sync");

        // R7: alternate link clock, 8 bus cycles per link clock
        clk_sw = 1'b1;
        wait_clk(20);
        run_vec({1'b0, 8'hC3}, 8, "R7 alt");
        run_vec({1'b1, 8'h6A}, 8, "R7 alt");
        do_sync(8, 1400, 128, 150);
        clk_sw = 1'b0;
        wait_clk(20);
        run_vec({1'b0, 8'h3B}, 1, "R7 back to bus");

        chk("R3 no high drive against host", clash_cnt, 0);
        finish_run();
    end

endmodule